// File: doc/BRIEF.md
# Receive Queue Index Manager

This block keeps the bookkeeping for a circular queue of receive message buffers in a time-triggered bus controller. Frames that arrive in a slot with no dedicated buffer are steered into the queue. The block turns the incoming frame stream into memory writes: payload words go to the data field of the current entry, and the header word goes to the header slot that the write index selects. An entry becomes visible to the host only when the frame's status reports it valid. A frame with bad status leaves the write index where it is, so the next frame overwrites the same entry.

The host sees a not-empty flag and a read index that points at the oldest valid header. After it has consumed that entry, it writes 1 to the flag. That write retires the entry and moves the read index on. The flag drops only when nothing is left. A separate configuration write sets the first header index, the queue depth and the payload length of each entry. Such a write is taken only while the controller is in its configuration state and the depth is at least 2. An accepted write restarts both indices at the first header index.

Top module: `rxq_index_mgr`

## Requirements
- R1: A configuration write (`cfg_we`) changes the start, depth and size registers only when `cfg_mode` is high and `cfg_depth` is 2 or more. Any other write leaves all three unchanged. After reset the registers read start 0, depth 2, size 1.
- R2: An accepted configuration write loads the start value into both the read and the write index. It also clears the not-empty flag and the overflow bit, and abandons any frame in progress.
- R3: A frame whose `rx_owned` is high at `rx_begin` causes no memory write and no change to any index or flag.
- R4: Payload word k (counting from 0) of an accepted frame is written one cycle after it arrives, to address DATA_BASE + (write index − start) × size + k. Words with k ≥ size are dropped.
- R5: At `rx_end` of an accepted frame, `rx_hdr` is written one cycle later to the address equal to the current write index (the header area starts at address 0).
- R6: The write index advances at `rx_end` only when `rx_ok` is high and the queue is not full. With `rx_ok` low the index stays, and the next frame reuses the same entry.
- R7: Advancing the write index sets the not-empty flag in the same clock edge.
- R8: Both indices step from start+depth−1 back to start. Otherwise they step by 1.
- R9: `host_ack` while the flag is set moves the read index one entry on. The flag stays set while entries remain and clears once the queue is empty. `host_ack` with the flag clear changes nothing.
- R10: When depth−1 entries are held (queue full), a valid frame end is not committed and the sticky overflow bit is set. Only R2 clears the overflow bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 1 | Controller is in its configuration state |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_start | input | IDX_W | First header index of the queue |
| cfg_depth | input | DEPTH_W | Number of entries |
| cfg_size | input | SIZE_W | Payload words per entry |
| rx_begin | input | 1 | Start of a received frame |
| rx_owned | input | 1 | Slot has a dedicated buffer (qualifies rx_begin) |
| rx_word_vld | input | 1 | Payload word valid |
| rx_word | input | DATA_W | Payload word |
| rx_end | input | 1 | End of frame, status valid |
| rx_ok | input | 1 | Frame status is valid (qualifies rx_end) |
| rx_hdr | input | DATA_W | Header and slot status word (qualifies rx_end) |
| host_ack | input | 1 | Host writes 1 to the not-empty flag |
| cfg_start_o | output | IDX_W | Current start register |
| cfg_depth_o | output | DEPTH_W | Current depth register |
| cfg_size_o | output | SIZE_W | Current size register |
| rd_idx_o | output | IDX_W | Header index of the oldest valid entry |
| wr_idx_o | output | IDX_W | Header index that the next frame fills |
| nempty_o | output | 1 | Not-empty interrupt flag |
| ovf_o | output | 1 | Sticky overflow bit |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |

## Verification
The bench replays a sequence of frames that differ in one feature at a time:
- a frame in an owned slot, which tells a filtered frame from an accepted one;
- a frame with bad status followed by a good one on the same entry, which tells reuse from advance;
- a frame longer than the entry, which shows the payload clipping;
- frames that push the queue to full and past it, which separate commit from overflow.

Host acknowledges are applied with two entries held, with one held, and with none held, which tells the flag staying set apart from clearing and from being ignored. A commit and an acknowledge at start+depth−1 show the wrap of each index. A reconfiguration while entries are held, followed by a frame of a different size, shows that the indices restart and that the payload stride changes.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [0:0] {
    FS_IDLE    = 1'b0,
    FS_CAPTURE = 1'b1
  } frame_state_e;
endpackage

// File: rtl/rxq_cfg_regs.sv
module rxq_cfg_regs #(
  parameter int IDX_W   = 7,
  parameter int DEPTH_W = 7,
  parameter int SIZE_W  = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_mode,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_start,
  input  logic [DEPTH_W-1:0] cfg_depth,
  input  logic [SIZE_W-1:0]  cfg_size,
  output logic [IDX_W-1:0]   start_q,
  output logic [DEPTH_W-1:0] depth_q,
  output logic [SIZE_W-1:0]  size_q,
  output logic               cfg_load
);
  localparam logic [DEPTH_W-1:0] MIN_DEPTH = DEPTH_W'(2);

  assign cfg_load = cfg_we && cfg_mode && (cfg_depth >= MIN_DEPTH);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      depth_q <= MIN_DEPTH;
      size_q  <= SIZE_W'(1);
    end else if (cfg_load) begin
      start_q <= cfg_start;
      depth_q <= cfg_depth;
      size_q  <= cfg_size;
    end
  end
endmodule

// File: rtl/rxq_ring_ctrl.sv
module rxq_ring_ctrl #(
  parameter int IDX_W   = 7,
  parameter int DEPTH_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_load,
  input  logic [IDX_W-1:0]   cfg_start_in,
  input  logic [IDX_W-1:0]   start_q,
  input  logic [DEPTH_W-1:0] depth_q,
  input  logic               commit_req,
  input  logic               host_ack,
  output logic [IDX_W-1:0]   wr_idx,
  output logic [IDX_W-1:0]   rd_idx,
  output logic               nempty,
  output logic               ovf
);
  localparam int EXT_W = IDX_W + 1;

  logic [DEPTH_W-1:0] cnt_q, cnt_n;
  logic [EXT_W-1:0]   last_w;
  logic [IDX_W-1:0]   wr_nx, rd_nx;
  logic               full, do_push, do_pop, ovf_hit;

  always_comb begin
    last_w  = {1'b0, start_q} + EXT_W'(depth_q) - EXT_W'(1);
    wr_nx   = ({1'b0, wr_idx} == last_w) ? start_q : wr_idx + IDX_W'(1);
    rd_nx   = ({1'b0, rd_idx} == last_w) ? start_q : rd_idx + IDX_W'(1);
    full    = (cnt_q == depth_q - DEPTH_W'(1));
    do_push = commit_req && !full;
    ovf_hit = commit_req && full;
    do_pop  = host_ack && nempty;
    cnt_n   = cnt_q + DEPTH_W'(do_push) - DEPTH_W'(do_pop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx <= '0;
      rd_idx <= '0;
      cnt_q  <= '0;
      nempty <= 1'b0;
      ovf    <= 1'b0;
    end else if (cfg_load) begin
      wr_idx <= cfg_start_in;
      rd_idx <= cfg_start_in;
      cnt_q  <= '0;
      nempty <= 1'b0;
      ovf    <= 1'b0;
    end else begin
      if (do_push) wr_idx <= wr_nx;
      if (do_pop)  rd_idx <= rd_nx;
      cnt_q  <= cnt_n;
      nempty <= (cnt_n != '0);
      if (ovf_hit) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/rxq_wr_port.sv
module rxq_wr_port
  import rxq_pkg::*;
#(
  parameter int IDX_W     = 7,
  parameter int SIZE_W    = 6,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 16,
  parameter int DATA_BASE = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic              rx_begin,
  input  logic              rx_owned,
  input  logic              rx_word_vld,
  input  logic [DATA_W-1:0] rx_word,
  input  logic              rx_end,
  input  logic              rx_ok,
  input  logic [DATA_W-1:0] rx_hdr,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [IDX_W-1:0]  start_q,
  input  logic [SIZE_W-1:0] size_q,
  output logic              commit_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  frame_state_e      st_q;
  logic [SIZE_W-1:0] wcnt_q;
  logic [IDX_W-1:0]  rel;
  logic [ADDR_W-1:0] data_addr;
  logic              capturing, word_take, hdr_take;

  always_comb begin
    capturing  = (st_q == FS_CAPTURE);
    rel        = wr_idx - start_q;
    data_addr  = ADDR_W'(DATA_BASE) + ADDR_W'(rel) * ADDR_W'(size_q) + ADDR_W'(wcnt_q);
    word_take  = capturing && rx_word_vld && (wcnt_q < size_q);
    hdr_take   = capturing && rx_end;
    commit_req = hdr_take && rx_ok && !cfg_load;
  end

  always_ff @(posedge clk) begin
    if (rst || cfg_load) begin
      st_q   <= FS_IDLE;
      wcnt_q <= '0;
    end else if (rx_begin) begin
      st_q   <= rx_owned ? FS_IDLE : FS_CAPTURE;
      wcnt_q <= '0;
    end else if (hdr_take) begin
      st_q <= FS_IDLE;
    end else if (word_take) begin
      wcnt_q <= wcnt_q + SIZE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cfg_load) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= hdr_take || word_take;
      if (hdr_take) begin
        mem_addr  <= ADDR_W'(wr_idx);
        mem_wdata <= rx_hdr;
      end else if (word_take) begin
        mem_addr  <= data_addr;
        mem_wdata <= rx_word;
      end
    end
  end
endmodule

// File: rtl/rxq_index_mgr.sv
module rxq_index_mgr #(
  parameter int IDX_W     = 7,
  parameter int DEPTH_W   = 7,
  parameter int SIZE_W    = 6,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 16,
  parameter int DATA_BASE = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_mode,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_start,
  input  logic [DEPTH_W-1:0] cfg_depth,
  input  logic [SIZE_W-1:0]  cfg_size,
  input  logic               rx_begin,
  input  logic               rx_owned,
  input  logic               rx_word_vld,
  input  logic [DATA_W-1:0]  rx_word,
  input  logic               rx_end,
  input  logic               rx_ok,
  input  logic [DATA_W-1:0]  rx_hdr,
  input  logic               host_ack,
  output logic [IDX_W-1:0]   cfg_start_o,
  output logic [DEPTH_W-1:0] cfg_depth_o,
  output logic [SIZE_W-1:0]  cfg_size_o,
  output logic [IDX_W-1:0]   rd_idx_o,
  output logic [IDX_W-1:0]   wr_idx_o,
  output logic               nempty_o,
  output logic               ovf_o,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata
);
  logic cfg_load, commit_req;

  rxq_cfg_regs #(.IDX_W(IDX_W), .DEPTH_W(DEPTH_W), .SIZE_W(SIZE_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_we(cfg_we),
    .cfg_start(cfg_start), .cfg_depth(cfg_depth), .cfg_size(cfg_size),
    .start_q(cfg_start_o), .depth_q(cfg_depth_o), .size_q(cfg_size_o),
    .cfg_load(cfg_load)
  );

  rxq_ring_ctrl #(.IDX_W(IDX_W), .DEPTH_W(DEPTH_W)) u_ring (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_start_in(cfg_start),
    .start_q(cfg_start_o), .depth_q(cfg_depth_o), .commit_req(commit_req),
    .host_ack(host_ack), .wr_idx(wr_idx_o), .rd_idx(rd_idx_o),
    .nempty(nempty_o), .ovf(ovf_o)
  );

  rxq_wr_port #(.IDX_W(IDX_W), .SIZE_W(SIZE_W), .ADDR_W(ADDR_W),
                .DATA_W(DATA_W), .DATA_BASE(DATA_BASE)) u_wr (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .rx_begin(rx_begin),
    .rx_owned(rx_owned), .rx_word_vld(rx_word_vld), .rx_word(rx_word),
    .rx_end(rx_end), .rx_ok(rx_ok), .rx_hdr(rx_hdr), .wr_idx(wr_idx_o),
    .start_q(cfg_start_o), .size_q(cfg_size_o), .commit_req(commit_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );
endmodule

// File: rtl/rxq_index_mgr_chk.sv
module rxq_index_mgr_chk #(
  parameter int IDX_W   = 7,
  parameter int DEPTH_W = 7,
  parameter int SIZE_W  = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               cfg_mode,
  input logic               cfg_we,
  input logic               rx_word_vld,
  input logic               rx_end,
  input logic               rx_ok,
  input logic               host_ack,
  input logic [IDX_W-1:0]   cfg_start_o,
  input logic [DEPTH_W-1:0] cfg_depth_o,
  input logic [IDX_W-1:0]   rd_idx_o,
  input logic [IDX_W-1:0]   wr_idx_o,
  input logic               nempty_o,
  input logic               ovf_o,
  input logic               mem_we
);
  localparam int EXT_W = IDX_W + 1;
  logic [EXT_W-1:0] top_w;
  assign top_w = {1'b0, cfg_start_o} + EXT_W'(cfg_depth_o) - EXT_W'(1);

  // R1
  depth_min_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_depth_o >= DEPTH_W'(2));

  // R1
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && cfg_mode) |=> $stable(cfg_depth_o));

  // R8
  rd_window_chk: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, rd_idx_o} >= {1'b0, cfg_start_o}) && ({1'b0, rd_idx_o} <= top_w));

  // R6
  wr_move_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(wr_idx_o) |-> $past(rx_end && rx_ok) || $past(cfg_we && cfg_mode));

  // R9
  flag_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(nempty_o) |-> $past(host_ack) || $past(cfg_we && cfg_mode));

  // R10
  ovf_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_o) |-> $past(rx_end && rx_ok));

  // R4
  we_cause_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(rx_word_vld || rx_end));
endmodule

bind rxq_index_mgr rxq_index_mgr_chk #(.IDX_W(IDX_W), .DEPTH_W(DEPTH_W), .SIZE_W(SIZE_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_we(cfg_we),
  .rx_word_vld(rx_word_vld), .rx_end(rx_end), .rx_ok(rx_ok), .host_ack(host_ack),
  .cfg_start_o(cfg_start_o), .cfg_depth_o(cfg_depth_o), .rd_idx_o(rd_idx_o),
  .wr_idx_o(wr_idx_o), .nempty_o(nempty_o), .ovf_o(ovf_o), .mem_we(mem_we)
);

// File: tb/rxq_index_mgr_bench.sv
module rxq_index_mgr_bench;
  localparam int IDX_W = 7, DEPTH_W = 7, SIZE_W = 6, ADDR_W = 12, DATA_W = 16, DATA_BASE = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_mode = 0, cfg_we = 0;
  logic [IDX_W-1:0] cfg_start = '0;
  logic [DEPTH_W-1:0] cfg_depth = '0;
  logic [SIZE_W-1:0] cfg_size = '0;
  logic rx_begin = 0, rx_owned = 0, rx_word_vld = 0, rx_end = 0, rx_ok = 0, host_ack = 0;
  logic [DATA_W-1:0] rx_word = '0, rx_hdr = '0;
  logic [IDX_W-1:0] cfg_start_o, rd_idx_o, wr_idx_o;
  logic [DEPTH_W-1:0] cfg_depth_o;
  logic [SIZE_W-1:0] cfg_size_o;
  logic nempty_o, ovf_o, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;

  always #2 clk = ~clk;

  rxq_index_mgr u_rxq_index_mgr (.*);

  int errors = 0, checks = 0;
  bit done = 0;
  int exp_q[$];
  int m_start = 0, m_depth = 2, m_size = 1, m_wr = 0, m_rd = 0, m_cnt = 0;
  bit m_ovf = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: compares each memory write against the scoreboard (R4, R5)
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3/R4 unexpected write actual=%0d expected=none", int'(mem_addr));
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != ((int'(mem_addr) << 16) | int'(mem_wdata))) begin
          errors++;
          $display("FAIL R4/R5 write actual=%0h expected=%0h",
                   (int'(mem_addr) << 16) | int'(mem_wdata), e);
        end
      end
    end
  end

  function automatic int nxt(int i);
    return (i == m_start + m_depth - 1) ? m_start : i + 1;
  endfunction

  task automatic cfg_write(bit mode, int st, int dp, int sz);
    @(negedge clk);
    cfg_mode = mode; cfg_we = 1; cfg_start = IDX_W'(st); cfg_depth = DEPTH_W'(dp); cfg_size = SIZE_W'(sz);
    @(negedge clk);
    cfg_we = 0; cfg_mode = 0;
    if (mode && dp >= 2) begin
      m_start = st; m_depth = dp; m_size = sz;
      m_wr = st; m_rd = st; m_cnt = 0; m_ovf = 0;
    end
  endtask

  task automatic send_frame(bit owned, int nwords, bit ok, int hdr);
    int rel;
    rel = m_wr - m_start;
    if (!owned) begin
      for (int k = 0; k < nwords && k < m_size; k++)
        exp_q.push_back(((DATA_BASE + rel * m_size + k) << 16) | ((hdr + k + 1) & 16'hffff));
      exp_q.push_back((m_wr << 16) | hdr);
    end
    @(negedge clk);
    rx_begin = 1; rx_owned = owned;
    @(negedge clk);
    rx_begin = 0; rx_owned = 0;
    for (int k = 0; k < nwords; k++) begin
      rx_word_vld = 1; rx_word = DATA_W'(hdr + k + 1);
      @(negedge clk);
    end
    rx_word_vld = 0;
    rx_end = 1; rx_ok = ok; rx_hdr = DATA_W'(hdr);
    @(negedge clk);
    rx_end = 0; rx_ok = 0;
    if (!owned && ok) begin
      if (m_cnt == m_depth - 1) m_ovf = 1;
      else begin m_wr = nxt(m_wr); m_cnt++; end
    end
    @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk);
    host_ack = 1;
    @(negedge clk);
    host_ack = 0;
    if (m_cnt > 0) begin m_rd = nxt(m_rd); m_cnt--; end
  endtask

  task automatic check_state(string tag);
    check({tag, " rd_idx"}, int'(rd_idx_o), m_rd);
    check({tag, " wr_idx"}, int'(wr_idx_o), m_wr);
    check({tag, " nempty"}, int'(nempty_o), int'(m_cnt != 0));
    check({tag, " ovf"}, int'(ovf_o), int'(m_ovf));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset start", int'(cfg_start_o), 0);
    check("R1 reset depth", int'(cfg_depth_o), 2);
    check("R1 reset size", int'(cfg_size_o), 1);
    check_state("R1 reset");

    cfg_write(0, 4, 3, 2);
    check("R1 write outside config", int'(cfg_start_o), 0);
    cfg_write(1, 4, 1, 2);
    check("R1 depth below 2 start", int'(cfg_start_o), 0);
    check("R1 depth below 2 depth", int'(cfg_depth_o), 2);
    cfg_write(1, 4, 3, 2);
    check("R1 accepted start", int'(cfg_start_o), 4);
    check("R1 accepted depth", int'(cfg_depth_o), 3);
    check("R1 accepted size", int'(cfg_size_o), 2);
    check_state("R2 after config");

    send_frame(1, 2, 1, 16'h0100);
    check_state("R3 owned slot");
    send_frame(0, 2, 0, 16'h0200);
    check_state("R6 bad status");
    send_frame(0, 3, 1, 16'h0300);
    check_state("R6 R7 R4 commit with clipping");
    send_frame(0, 1, 1, 16'h0400);
    check_state("R6 second commit");
    send_frame(0, 2, 1, 16'h0500);
    check_state("R10 full overflow");

    ack();
    check_state("R9 ack with entries left");
    ack();
    check_state("R9 ack to empty");
    ack();
    check_state("R9 ack when empty");

    send_frame(0, 2, 1, 16'h0600);
    check_state("R8 write wrap");
    ack();
    check_state("R8 read wrap");

    send_frame(0, 1, 1, 16'h0700);
    check_state("R7 before reconfig");
    cfg_write(1, 10, 4, 3);
    check_state("R2 reconfig clears");
    send_frame(0, 3, 1, 16'h0800);
    check_state("R4 new stride");

    repeat (3) @(negedge clk);
    check("R4 scoreboard drained", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule